// File: doc/BRIEF.md
# Serial-Controlled Programmable I/O Latch Port

This block is a small control port for a larger device. A host talks to it over a chip-select-gated serial link that has a control clock, a data input and a separately enabled data output. Over this link the host can read and write three registers. The first is a per-pin direction register. The second is an interface latch register whose bits drive or capture six general-purpose pins. The third is an 8-bit control register that only stores power-down and timing-mode bits for the rest of the device.

The control clock may run asynchronously to everything else. The block therefore samples the control clock, chip select, serial data and pin levels into its own system clock domain through synchronizer stages, and works from the edges it finds there. A write frame is acted on only when chip select rises after exactly sixteen control-clock edges. At that moment every pin set as an input is also captured into the latch register, and a later read can return that snapshot. An active-high master reset, synchronous to the system clock, returns all registers to their defaults at any time.

Top module: `serial_latch_port`

## Requirements
- R1: After master reset the direction register is 0 (all pins inputs, `pin_oe` all low), the latch register is 0, the control register is 8'h80 (bit 7 = power-down set, bit 6 = delayed timing clear) and `ctrl_sdo_oe` is low.
- R2: A frame is an instruction byte followed by a data byte, each sent MSB first. Instruction bits [7:6] select the register (00 control, 01 latch, 10 direction, 11 none) and bit 0 selects read (1) or write (0). A write to address 11 stores nothing, and a read of it returns 0.
- R3: A complete write to the direction register sets `pin_oe` to its low six data bits (1 = output) once chip select has risen. Writing 0 returns the pins to high impedance.
- R4: Pins whose direction bit is 1 drive the stored latch bit on `pin_out`, and a write to the latch register sets those bits to the written data.
- R5: On every complete write frame, whatever its target, each latch bit whose direction bit (the value before the write) is 0 takes the level of its `pin_in` bit. A read frame takes no snapshot.
- R6: A read returns the addressed register MSB first on `ctrl_sdo`. One bit becomes valid for each control-clock rising edge from the 9th to the 16th, and the six-bit registers are zero-extended to 8 bits.
- R7: `ctrl_sdo_oe` is high only during the data byte of a read frame. It is low during the instruction byte, during write frames and while chip select is high.
- R8: A frame with fewer or more than 16 control-clock rising edges before chip select rises changes no register and takes no snapshot.
- R9: Control-clock edges while chip select is high are ignored and do not disturb the next frame.
- R10: Master reset restores the defaults of R1 even in the middle of a frame, and the interrupted frame has no effect.
- R11: The control register stores and reads back all 8 written bits and appears on `ctrl_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mr | input | 1 | Master reset, active high, synchronous |
| ctrl_clk | input | 1 | Serial control clock, asynchronous |
| ctrl_csn | input | 1 | Chip select, active low |
| ctrl_sdi | input | 1 | Serial control data in |
| ctrl_sdo | output | 1 | Serial read data out |
| ctrl_sdo_oe | output | 1 | Output enable for `ctrl_sdo`, low means high impedance |
| pin_in | input | PIN_W | Levels sensed on the interface pins |
| pin_out | output | PIN_W | Values driven onto the interface pins |
| pin_oe | output | PIN_W | Per-pin drive enable (the direction register) |
| ctrl_reg | output | BYTE_W | Stored control register |

## Verification
The bench sends write frames to each address with mixed direction patterns (alternating bits, all outputs, all inputs), so a wrong mask between written data and sensed pin levels shows on `pin_out`. It then changes `pin_in` between reads and writes, which tells a snapshot taken at write commit apart from one taken on reads or from a live pin. Truncated and over-long frames, idle control-clock activity and a reset in the middle of a frame check that only exact 16-bit frames commit. Reads of every address check both the bit order on `ctrl_sdo` and the exact window in which the output is enabled.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL  = 2'b00,
    ADR_LATCH = 2'b01,
    ADR_DIR   = 2'b10,
    ADR_NONE  = 2'b11
  } slp_addr_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slp_shift.sv
module slp_shift
  import slp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output slp_addr_e         rd_addr,
  output logic              commit,
  output slp_addr_e         wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int FRAME = 2 * BYTE_W;
  localparam int CNT_W = $clog2(FRAME + 2);

  logic              sclk_d, csn_d;
  logic [CNT_W-1:0]  cnt;
  logic [FRAME-1:0]  shreg;
  logic [BYTE_W-1:0] outsh;
  logic              rise, fall, cs_rise;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign cs_rise = csn_s & ~csn_d;

  // instruction bits seen so far: bit 7 at [BYTE_W-2] before the 8th edge
  assign rd_addr = slp_addr_e'(shreg[BYTE_W-2 -: 2]);
  assign wr_addr = slp_addr_e'(shreg[FRAME-1 -: 2]);
  assign wr_data = shreg[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
      outsh  <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      commit <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      commit <= 1'b0;
      if (csn_s) begin
        cnt    <= '0;
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
        if (cs_rise && cnt == CNT_W'(FRAME) && !shreg[BYTE_W]) commit <= 1'b1;
      end else begin
        if (rise) begin
          if (cnt <= CNT_W'(FRAME)) cnt <= cnt + 1'b1;
          shreg <= {shreg[FRAME-2:0], sdi_s};
          if (cnt == CNT_W'(BYTE_W - 1) && sdi_s) begin
            sdo    <= rd_data[BYTE_W-1];
            outsh  <= rd_data << 1;
            sdo_oe <= 1'b1;
          end
          if (cnt == CNT_W'(FRAME - 1)) sdo_oe <= 1'b0;
        end
        if (fall && sdo_oe && cnt >= CNT_W'(BYTE_W + 1)) begin
          sdo   <= outsh[BYTE_W-1];
          outsh <= outsh << 1;
        end
      end
    end
  end

  // R7
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (csn_s && csn_d) |-> !sdo_oe);

  // R8
  commit_full_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(cnt) == CNT_W'(FRAME)));
endmodule

// File: rtl/slp_regs.sv
module slp_regs
  import slp_pkg::*;
#(
  parameter int               PIN_W    = 6,
  parameter int               BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] CTRL_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  slp_addr_e         wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PIN_W-1:0]  pins_s,
  input  slp_addr_e         rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [PIN_W-1:0]  ldr,
  output logic [PIN_W-1:0]  ilr,
  output logic [BYTE_W-1:0] ctrl
);
  logic [PIN_W-1:0] ilr_nxt;

  genvar g;
  generate
    for (g = 0; g < PIN_W; g++) begin : g_pin
      assign ilr_nxt[g] = ldr[g] ? ((wr_addr == ADR_LATCH) ? wr_data[g] : ilr[g])
                                 : pins_s[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ldr  <= '0;
      ilr  <= '0;
      ctrl <= CTRL_RST;
    end else if (commit) begin
      ilr <= ilr_nxt;
      if (wr_addr == ADR_DIR)  ldr  <= wr_data[PIN_W-1:0];
      if (wr_addr == ADR_CTRL) ctrl <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_CTRL:  rd_data = ctrl;
      ADR_LATCH: rd_data = BYTE_W'(ilr);
      ADR_DIR:   rd_data = BYTE_W'(ldr);
      default:   rd_data = '0;
    endcase
  end

  // R1
  rst_default_chk: assert property (@(posedge clk)
    rst |=> (ldr == '0 && ilr == '0 && ctrl == CTRL_RST));

  // R5
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (((ilr ^ $past(pins_s)) & ~$past(ldr)) == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(ldr) && $stable(ilr) && $stable(ctrl)));
endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port
  import slp_pkg::*;
#(
  parameter int PIN_W  = 6,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              mr,
  input  logic              ctrl_clk,
  input  logic              ctrl_csn,
  input  logic              ctrl_sdi,
  output logic              ctrl_sdo,
  output logic              ctrl_sdo_oe,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [BYTE_W-1:0] ctrl_reg
);
  localparam int SW = PIN_W + 3;

  logic [SW-1:0]     raw, synced;
  logic              sclk_s, csn_s, sdi_s;
  logic [PIN_W-1:0]  pins_s;
  logic [BYTE_W-1:0] rd_data, wr_data;
  slp_addr_e         rd_addr, wr_addr;
  logic              commit;

  assign raw = {ctrl_clk, ctrl_csn, ctrl_sdi, pin_in};
  assign {sclk_s, csn_s, sdi_s, pins_s} = synced;

  slp_sync #(
    .W(SW), .STAGES(SYNC_N), .RST_VAL({3'b010, {PIN_W{1'b0}}})
  ) u_sync (
    .clk(clk), .rst(mr), .d(raw), .q(synced)
  );

  slp_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(mr), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdo(ctrl_sdo), .sdo_oe(ctrl_sdo_oe)
  );

  slp_regs #(.PIN_W(PIN_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(mr), .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .pins_s(pins_s), .rd_addr(rd_addr), .rd_data(rd_data),
    .ldr(pin_oe), .ilr(pin_out), .ctrl(ctrl_reg)
  );
endmodule

// File: tb/tb_serial_latch_port.sv
module tb_serial_latch_port;
  logic       clk = 1'b0;
  logic       mr = 1'b1;
  logic       sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [5:0] pin_in = 6'h00;
  logic       sdo, sdo_oe;
  logic [5:0] pin_out, pin_oe;
  logic [7:0] ctrl_reg;

  logic [5:0] m_ldr = 6'h00, m_ilr = 6'h00;
  logic [7:0] m_ctrl = 8'h80;
  int  n_cmp = 0, n_bad = 0;
  bit  settled = 1'b0;
  bit  done = 1'b0;

  serial_latch_port dut (
    .clk(clk), .mr(mr), .ctrl_clk(sclk), .ctrl_csn(csn), .ctrl_sdi(sdi),
    .ctrl_sdo(sdo), .ctrl_sdo_oe(sdo_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_reg(ctrl_reg)
  );

  always #5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (settled) begin
      chk(pin_oe, m_ldr, "R3 direction");
      chk(pin_out, m_ilr, "R4 latch");
      chk(ctrl_reg, m_ctrl, "R11 control");
      if (csn) chk(sdo_oe, 0, "R7 idle output enable");
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'b00:   return m_ctrl;
      2'b01:   return {2'b00, m_ilr};
      2'b10:   return {2'b00, m_ldr};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_ldr = 6'h00; m_ilr = 6'h00; m_ctrl = 8'h80;
  endtask

  task automatic m_write(input logic [1:0] a, input logic [7:0] d);
    logic [5:0] old, lat;
    old = m_ldr;
    lat = (a == 2'b01) ? d[5:0] : m_ilr;
    m_ilr = (lat & old) | (pin_in & ~old);
    if (a == 2'b10) m_ldr = d[5:0];
    if (a == 2'b00) m_ctrl = d;
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [7:0] dat, input int nbits);
    logic [15:0] w;
    logic [7:0]  rexp;
    bit          rd;
    w    = {ins, dat};
    rd   = (nbits == 16) && ins[0];
    rexp = m_read(ins[7:6]);
    csn  = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = (i < 16) ? w[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (rd && i >= 8) begin
        chk(sdo_oe, 1, "R7 read data enable");
        chk(sdo, rexp[15-i], "R6 read bit");
      end else begin
        chk(sdo_oe, 0, "R7 no drive outside read data");
      end
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    settled = 1'b0;
    csn = 1'b1;
    if (nbits == 16 && !ins[0]) m_write(ins[7:6], dat);
    repeat (10) @(negedge clk);
    settled = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    mr = 1'b0;
    repeat (4) @(negedge clk);
    settled = 1'b1;
    // R1 defaults
    chk(pin_oe, 0, "R1 direction reset");
    chk(ctrl_reg, 8'h80, "R1 control reset");
    chk(sdo_oe, 0, "R1 output enable reset");

    xfer(8'h01, 8'h00, 16);            // R6 R11 read control default
    pin_in = 6'b010101;
    xfer(8'h80, 8'h2A, 16);            // R3 direction 101010, R5 snapshot
    chk(pin_oe, 6'h2A, "R3 direction written");
    chk(pin_out, 6'h15, "R5 snapshot with all inputs");
    xfer(8'h40, 8'h3F, 16);            // R4 outputs take data
    chk(pin_out, 6'h3F, "R4 output bits driven");
    pin_in = 6'b000000;
    xfer(8'h41, 8'h00, 16);            // R5 read takes no snapshot
    xfer(8'h00, 8'h5C, 16);            // R11 control write, R5 snapshot
    chk(pin_out, 6'h2A, "R5 input bits resampled");
    xfer(8'h01, 8'h00, 16);            // R6 read control
    xfer(8'h81, 8'h00, 16);            // R6 read direction
    xfer(8'h41, 8'h00, 16);            // R6 read latch

    // R8 short and long frames
    pin_in = 6'b111111;
    xfer(8'h80, 8'h00, 12);
    xfer(8'h80, 8'h00, 17);
    chk(pin_oe, 6'h2A, "R8 incomplete frame discarded");

    // R9 idle clocks with chip select high
    sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk;
      repeat (8) @(negedge clk);
    end
    sclk = 1'b0;
    xfer(8'h01, 8'h00, 16);            // R9 next frame intact

    // R2 unused address
    xfer(8'hC0, 8'hFF, 16);
    chk(ctrl_reg, 8'h5C, "R2 unused address write");
    xfer(8'hC1, 8'h00, 16);

    // R4 all outputs
    xfer(8'h80, 8'h3F, 16);
    xfer(8'h40, 8'h15, 16);
    chk(pin_out, 6'h15, "R4 all outputs");
    xfer(8'h80, 8'h00, 16);
    chk(pin_oe, 0, "R3 back to high impedance");

    // R10 reset in the middle of a frame
    xfer(8'h00, 8'h33, 16);
    settled = 1'b0;
    csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b0;
      sdi  = (i == 0) || (i >= 8);
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    sclk = 1'b0;
    mr = 1'b1;
    repeat (2) @(negedge clk);
    mr = 1'b0;
    m_reset();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (10) @(negedge clk);
    settled = 1'b1;
    chk(pin_oe, 0, "R10 direction after mid-frame reset");
    chk(ctrl_reg, 8'h80, "R10 control after mid-frame reset");
    xfer(8'h01, 8'h00, 16);            // R10 read back default

    repeat (5) @(negedge clk);
    summary();
  end
endmodule